// File: doc/BRIEF.md
# Speculative Register Alias Table with Write Forwarding

This block holds the mapping from architectural registers to physical registers for a rename stage. It keeps two copies: a speculative map that rename updates as instructions flow, and an architectural map that commit updates as instructions retire. Lookup addresses arrive one stage early, straight from the fetch buffer. The block performs the lookup in that cycle, registers the result, and presents it to rename in the following cycle.

Rename and commit updates are captured in a register and written into their map one cycle after they arrive. Updates are therefore delayed, while lookups are early. To hide both effects, each lookup is forwarded from the updates held in the register and from the updates presented in the same cycle. Rename always sees the newest mapping.

A redirect replaces the speculative map with the architectural one. It drops the rename updates that are in flight, and it marks the lookups issued in the redirect cycle as invalid. Architectural register 0 is bound to a fixed physical register.

Top module: `rename_alias_table`

## Requirements
- R1: After reset, architectural register 0 maps to physical register ZERO_PREG (default 0), every other entry i maps to physical register i, and every rd_valid bit is low.
- R2: A lookup presented on port i with rd_en[i] high in cycle T gives rd_valid[i] high and rd_preg[i] in cycle T+1. The result reflects every rename update presented in cycle T or earlier. A port with rd_en low gives rd_valid low.
- R3: A rename update presented in the same cycle as a lookup of the same register is forwarded into that lookup's result.
- R4: A rename update presented one cycle before a lookup is forwarded, even though it has not yet reached the map. When updates from different cycles target one entry, the update from the later cycle wins.
- R5: When several rename ports update the same entry in one cycle, the port with the highest index wins. This holds both for forwarding and for the stored map.
- R6: Updates to architectural register 0 are ignored on both the rename and the commit ports. A lookup of register 0 always returns ZERO_PREG.
- R7: When redirect is high in cycle T, the speculative map from T+1 on equals the architectural map, including all commit updates presented in cycle T or earlier. Rename updates presented in cycle T or cycle T-1 are discarded.
- R8: Lookups presented in a redirect cycle return rd_valid low.
- R9: Commit updates change only the architectural map, so they are invisible to lookups until a redirect. Among commit ports updating one entry in the same cycle, the highest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect | input | 1 | Restore speculative map from architectural map |
| rd_en | input | NUM_RD (4) | Lookup request per read port |
| rd_addr | input | NUM_RD x AW (4x5) | Architectural register to look up |
| rd_valid | output | NUM_RD (4) | Lookup result valid, one cycle after request |
| rd_preg | output | NUM_RD x PREG_W (4x7) | Physical register mapped to the looked-up register |
| ren_wen | input | NUM_REN (2) | Rename update enable, higher index is younger |
| ren_waddr | input | NUM_REN x AW (2x5) | Architectural register being renamed |
| ren_wpreg | input | NUM_REN x PREG_W (2x7) | New physical register for it |
| cmt_wen | input | NUM_CMT (2) | Commit update enable, higher index is younger |
| cmt_waddr | input | NUM_CMT x AW (2x5) | Architectural register being committed |
| cmt_wpreg | input | NUM_CMT x PREG_W (2x7) | Committed physical register |

## Verification
Suppose a forwarding term is missing or has the wrong priority. The first lookup that hits an update from the same cycle or from the previous cycle then returns a stale physical register, one cycle after that lookup is issued. A bad map entry stays hidden until that register is looked up. A bad architectural entry stays hidden until a redirect has been taken and that register is then looked up. For this reason the stimulus mixes lookups of a small set of registers with dense updates and frequent redirects, and compares every lookup against a model map that is updated in program order.

// File: rtl/rat_pkg.sv
package rat_pkg;
    parameter int unsigned RAT_NUM_ARCH  = 32;
    parameter int unsigned RAT_PREG_W    = 7;
    parameter int unsigned RAT_NUM_RD    = 4;
    parameter int unsigned RAT_NUM_REN   = 2;
    parameter int unsigned RAT_NUM_CMT   = 2;
    parameter int unsigned RAT_ZERO_PREG = 0;
endpackage

// File: rtl/rat_wr_latch.sv
module rat_wr_latch #(
    parameter int unsigned NP = 2,
    parameter int unsigned AW = 5,
    parameter int unsigned PW = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   kill,
    input  logic [NP-1:0]          in_en,
    input  logic [NP-1:0][AW-1:0]  in_addr,
    input  logic [NP-1:0][PW-1:0]  in_preg,
    output logic [NP-1:0]          q_en,
    output logic [NP-1:0][AW-1:0]  q_addr,
    output logic [NP-1:0][PW-1:0]  q_preg
);
    typedef struct packed {
        logic [NP-1:0]         en;
        logic [NP-1:0][AW-1:0] addr;
        logic [NP-1:0][PW-1:0] preg;
    } st_t;

    st_t s_d, s_q;

    // Updates to register 0 and updates seen under kill are dropped here.
    always_comb begin
        s_d      = s_q;
        s_d.addr = in_addr;
        s_d.preg = in_preg;
        for (int p = 0; p < NP; p++) begin
            s_d.en[p] = in_en[p] & ~kill & (in_addr[p] != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_en   = s_q.en;
    assign q_addr = s_q.addr;
    assign q_preg = s_q.preg;
endmodule

// File: rtl/rat_table.sv
module rat_table #(
    parameter int unsigned NENT      = 32,
    parameter int unsigned AW        = 5,
    parameter int unsigned PW        = 7,
    parameter int unsigned NP        = 2,
    parameter int unsigned ZERO_PREG = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [NENT-1:0][PW-1:0] load_map,
    input  logic [NP-1:0]           w_en,
    input  logic [NP-1:0][AW-1:0]   w_addr,
    input  logic [NP-1:0][PW-1:0]   w_preg,
    output logic [NENT-1:0][PW-1:0] map
);
    typedef struct packed {
        logic [NENT-1:0][PW-1:0] map;
    } st_t;

    st_t s_d, s_q;

    function automatic logic [NENT-1:0][PW-1:0] reset_map();
        logic [NENT-1:0][PW-1:0] m;
        for (int e = 0; e < NENT; e++) m[e] = PW'(e);
        m[0] = PW'(ZERO_PREG);
        return m;
    endfunction

    // Ports are applied in ascending order, so the highest index wins.
    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.map = load_map;
        end else begin
            for (int p = 0; p < NP; p++) begin
                if (w_en[p]) s_d.map[w_addr[p]] = w_preg[p];
            end
        end
        s_d.map[0] = PW'(ZERO_PREG);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.map <= reset_map();
        else        s_q     <= s_d;
    end

    assign map = s_q.map;
endmodule

// File: rtl/rat_fwd_lookup.sv
module rat_fwd_lookup #(
    parameter int unsigned NENT      = 32,
    parameter int unsigned AW        = 5,
    parameter int unsigned PW        = 7,
    parameter int unsigned NP        = 2,
    parameter int unsigned ZERO_PREG = 0
) (
    input  logic [AW-1:0]           addr,
    input  logic [NENT-1:0][PW-1:0] map,
    input  logic [NP-1:0]           old_en,
    input  logic [NP-1:0][AW-1:0]   old_addr,
    input  logic [NP-1:0][PW-1:0]   old_preg,
    input  logic [NP-1:0]           new_en,
    input  logic [NP-1:0][AW-1:0]   new_addr,
    input  logic [NP-1:0][PW-1:0]   new_preg,
    output logic [PW-1:0]           preg
);
    // Priority, lowest to highest: stored map, then latched updates in
    // port order, then same-cycle updates in port order.
    always_comb begin
        preg = map[addr];
        for (int p = 0; p < NP; p++) begin
            if (old_en[p] && old_addr[p] == addr) preg = old_preg[p];
        end
        for (int p = 0; p < NP; p++) begin
            if (new_en[p] && new_addr[p] == addr) preg = new_preg[p];
        end
        if (addr == '0) preg = PW'(ZERO_PREG);
    end
endmodule

// File: rtl/rename_alias_table.sv
module rename_alias_table #(
    parameter int unsigned NUM_ARCH  = rat_pkg::RAT_NUM_ARCH,
    parameter int unsigned PREG_W    = rat_pkg::RAT_PREG_W,
    parameter int unsigned NUM_RD    = rat_pkg::RAT_NUM_RD,
    parameter int unsigned NUM_REN   = rat_pkg::RAT_NUM_REN,
    parameter int unsigned NUM_CMT   = rat_pkg::RAT_NUM_CMT,
    parameter int unsigned ZERO_PREG = rat_pkg::RAT_ZERO_PREG,
    localparam int unsigned AW       = $clog2(NUM_ARCH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          redirect,
    input  logic [NUM_RD-1:0]             rd_en,
    input  logic [NUM_RD-1:0][AW-1:0]     rd_addr,
    output logic [NUM_RD-1:0]             rd_valid,
    output logic [NUM_RD-1:0][PREG_W-1:0] rd_preg,
    input  logic [NUM_REN-1:0]            ren_wen,
    input  logic [NUM_REN-1:0][AW-1:0]    ren_waddr,
    input  logic [NUM_REN-1:0][PREG_W-1:0] ren_wpreg,
    input  logic [NUM_CMT-1:0]            cmt_wen,
    input  logic [NUM_CMT-1:0][AW-1:0]    cmt_waddr,
    input  logic [NUM_CMT-1:0][PREG_W-1:0] cmt_wpreg
);
    // Latched update stages
    logic [NUM_REN-1:0]             ren_pend_en;
    logic [NUM_REN-1:0][AW-1:0]     ren_pend_addr;
    logic [NUM_REN-1:0][PREG_W-1:0] ren_pend_preg;
    logic [NUM_CMT-1:0]             cmt_pend_en;
    logic [NUM_CMT-1:0][AW-1:0]     cmt_pend_addr;
    logic [NUM_CMT-1:0][PREG_W-1:0] cmt_pend_preg;

    rat_wr_latch #(.NP(NUM_REN), .AW(AW), .PW(PREG_W)) u_ren_latch (
        .clk(clk), .rst_n(rst_n), .kill(redirect),
        .in_en(ren_wen), .in_addr(ren_waddr), .in_preg(ren_wpreg),
        .q_en(ren_pend_en), .q_addr(ren_pend_addr), .q_preg(ren_pend_preg)
    );

    rat_wr_latch #(.NP(NUM_CMT), .AW(AW), .PW(PREG_W)) u_cmt_latch (
        .clk(clk), .rst_n(rst_n), .kill(1'b0),
        .in_en(cmt_wen), .in_addr(cmt_waddr), .in_preg(cmt_wpreg),
        .q_en(cmt_pend_en), .q_addr(cmt_pend_addr), .q_preg(cmt_pend_preg)
    );

    // Maps
    logic [NUM_ARCH-1:0][PREG_W-1:0] spec_map;
    logic [NUM_ARCH-1:0][PREG_W-1:0] arch_map;
    logic [NUM_ARCH-1:0][PREG_W-1:0] arch_eff;

    rat_table #(
        .NENT(NUM_ARCH), .AW(AW), .PW(PREG_W), .NP(NUM_REN), .ZERO_PREG(ZERO_PREG)
    ) u_spec (
        .clk(clk), .rst_n(rst_n), .load(redirect), .load_map(arch_eff),
        .w_en(ren_pend_en), .w_addr(ren_pend_addr), .w_preg(ren_pend_preg),
        .map(spec_map)
    );

    rat_table #(
        .NENT(NUM_ARCH), .AW(AW), .PW(PREG_W), .NP(NUM_CMT), .ZERO_PREG(ZERO_PREG)
    ) u_arch (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .load_map(arch_map),
        .w_en(cmt_pend_en), .w_addr(cmt_pend_addr), .w_preg(cmt_pend_preg),
        .map(arch_map)
    );

    // Architectural view that includes latched and same-cycle commits,
    // used as the reload source on redirect.
    for (genvar e = 0; e < NUM_ARCH; e++) begin : g_arch_eff
        rat_fwd_lookup #(
            .NENT(NUM_ARCH), .AW(AW), .PW(PREG_W), .NP(NUM_CMT), .ZERO_PREG(ZERO_PREG)
        ) u_eff (
            .addr(AW'(e)), .map(arch_map),
            .old_en(cmt_pend_en), .old_addr(cmt_pend_addr), .old_preg(cmt_pend_preg),
            .new_en(cmt_wen), .new_addr(cmt_waddr), .new_preg(cmt_wpreg),
            .preg(arch_eff[e])
        );
    end

    // Early lookups with forwarding
    logic [NUM_RD-1:0][PREG_W-1:0] look_preg;

    for (genvar i = 0; i < NUM_RD; i++) begin : g_rd
        rat_fwd_lookup #(
            .NENT(NUM_ARCH), .AW(AW), .PW(PREG_W), .NP(NUM_REN), .ZERO_PREG(ZERO_PREG)
        ) u_look (
            .addr(rd_addr[i]), .map(spec_map),
            .old_en(ren_pend_en), .old_addr(ren_pend_addr), .old_preg(ren_pend_preg),
            .new_en(ren_wen), .new_addr(ren_waddr), .new_preg(ren_wpreg),
            .preg(look_preg[i])
        );
    end

    // Result register
    typedef struct packed {
        logic [NUM_RD-1:0]             vld;
        logic [NUM_RD-1:0][PREG_W-1:0] preg;
    } rd_st_t;

    rd_st_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.vld  = rd_en & ~{NUM_RD{redirect}};
        r_d.preg = look_preg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_valid = r_q.vld;
    assign rd_preg  = r_q.preg;
endmodule

// File: rtl/rat_chk.sv
module rat_chk #(
    parameter int unsigned NUM_RD    = 4,
    parameter int unsigned NUM_REN   = 2,
    parameter int unsigned AW        = 5,
    parameter int unsigned PREG_W    = 7,
    parameter int unsigned ZERO_PREG = 0
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           redirect,
    input logic [NUM_RD-1:0]              rd_en,
    input logic [NUM_RD-1:0][AW-1:0]      rd_addr,
    input logic [NUM_RD-1:0]              rd_valid,
    input logic [NUM_RD-1:0][PREG_W-1:0]  rd_preg,
    input logic [NUM_REN-1:0]             ren_wen,
    input logic [NUM_REN-1:0][AW-1:0]     ren_waddr,
    input logic [NUM_REN-1:0][PREG_W-1:0] ren_wpreg
);
    // R8
    redirect_kills_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (rd_valid == '0));

    for (genvar i = 0; i < NUM_RD; i++) begin : g_port
        // R2
        read_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en[i] && !redirect) |=> rd_valid[i]);

        // R2
        idle_port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en[i] |=> !rd_valid[i]);

        // R6
        zero_reg_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en[i] && !redirect && rd_addr[i] == '0) |=> (rd_preg[i] == PREG_W'(ZERO_PREG)));

        // R3 and R5: the youngest rename port always wins a same-cycle hit
        same_cycle_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en[i] && !redirect && ren_wen[NUM_REN-1] && ren_waddr[NUM_REN-1] != '0
             && ren_waddr[NUM_REN-1] == rd_addr[i])
            |=> (rd_preg[i] == $past(ren_wpreg[NUM_REN-1])));
    end
endmodule

bind rename_alias_table rat_chk #(
    .NUM_RD(NUM_RD), .NUM_REN(NUM_REN), .AW(AW), .PREG_W(PREG_W), .ZERO_PREG(ZERO_PREG)
) u_rat_chk (
    .clk(clk), .rst_n(rst_n), .redirect(redirect),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_preg(rd_preg),
    .ren_wen(ren_wen), .ren_waddr(ren_waddr), .ren_wpreg(ren_wpreg)
);

// File: tb/tb_rename_alias_table.sv
`timescale 1ns/1ps
module tb_rename_alias_table;
    localparam int NA = rat_pkg::RAT_NUM_ARCH;
    localparam int PW = rat_pkg::RAT_PREG_W;
    localparam int NR = rat_pkg::RAT_NUM_RD;
    localparam int NW = rat_pkg::RAT_NUM_REN;
    localparam int NC = rat_pkg::RAT_NUM_CMT;
    localparam int ZP = rat_pkg::RAT_ZERO_PREG;
    localparam int AW = $clog2(NA);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic redirect;
    logic [NR-1:0] rd_en;
    logic [NR-1:0][AW-1:0] rd_addr;
    logic [NR-1:0] rd_valid;
    logic [NR-1:0][PW-1:0] rd_preg;
    logic [NW-1:0] ren_wen;
    logic [NW-1:0][AW-1:0] ren_waddr;
    logic [NW-1:0][PW-1:0] ren_wpreg;
    logic [NC-1:0] cmt_wen;
    logic [NC-1:0][AW-1:0] cmt_waddr;
    logic [NC-1:0][PW-1:0] cmt_wpreg;

    always #2.5 clk = ~clk;

    rename_alias_table dut (
        .clk(clk), .rst_n(rst_n), .redirect(redirect),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_preg(rd_preg),
        .ren_wen(ren_wen), .ren_waddr(ren_waddr), .ren_wpreg(ren_wpreg),
        .cmt_wen(cmt_wen), .cmt_waddr(cmt_waddr), .cmt_wpreg(cmt_wpreg)
    );

    typedef struct {
        logic [NR-1:0]         vld;
        logic [NR-1:0][PW-1:0] preg;
        string                 tag;
    } exp_t;

    exp_t exp_q[$];
    int spec_m[NA];
    int arch_m[NA];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic idle();
        redirect = 1'b0;
        rd_en = '0; rd_addr = '0;
        ren_wen = '0; ren_waddr = '0; ren_wpreg = '0;
        cmt_wen = '0; cmt_waddr = '0; cmt_wpreg = '0;
    endtask

    // Driver: model the cycle in program order, queue the expected result,
    // then advance to the next negative edge.
    task automatic step(input string tag);
        exp_t e;
        if (redirect) begin
            for (int c = 0; c < NC; c++)
                if (cmt_wen[c] && cmt_waddr[c] != 0) arch_m[cmt_waddr[c]] = int'(cmt_wpreg[c]);
            for (int a = 0; a < NA; a++) spec_m[a] = arch_m[a];
            e.vld = '0;
        end else begin
            for (int w = 0; w < NW; w++)
                if (ren_wen[w] && ren_waddr[w] != 0) spec_m[ren_waddr[w]] = int'(ren_wpreg[w]);
            for (int c = 0; c < NC; c++)
                if (cmt_wen[c] && cmt_waddr[c] != 0) arch_m[cmt_waddr[c]] = int'(cmt_wpreg[c]);
            e.vld = rd_en;
        end
        for (int i = 0; i < NR; i++)
            e.preg[i] = (rd_addr[i] == 0) ? PW'(ZP) : PW'(spec_m[rd_addr[i]]);
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare one queued cycle per clock, just after the edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            for (int i = 0; i < NR; i++) begin
                n_cmp++;
                if (rd_valid[i] !== e.vld[i]) begin
                    n_bad++;
                    $display("FAIL %s port %0d valid: actual %b expected %b", e.tag, i, rd_valid[i], e.vld[i]);
                end else if (e.vld[i] && rd_preg[i] !== e.preg[i]) begin
                    n_bad++;
                    $display("FAIL %s port %0d preg: actual %0d expected %0d", e.tag, i, rd_preg[i], e.preg[i]);
                end
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
        end
    end

    initial begin
        idle();
        for (int a = 0; a < NA; a++) begin spec_m[a] = a; arch_m[a] = a; end
        spec_m[0] = ZP; arch_m[0] = ZP;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: no valid output straight out of reset
        n_cmp++;
        if (rd_valid !== '0) begin
            n_bad++;
            $display("FAIL R1 reset valid: actual %b expected 0", rd_valid);
        end

        // R1: identity mapping after reset
        for (int i = 0; i < NR; i++) begin rd_en[i] = 1'b1; rd_addr[i] = AW'(i); end
        step("R1");
        for (int i = 0; i < NR; i++) rd_addr[i] = AW'(NA - 1 - i);
        step("R1");
        idle();

        // R3: same-cycle forwarding
        ren_wen[0] = 1'b1; ren_waddr[0] = 5; ren_wpreg[0] = 40;
        rd_en[0] = 1'b1; rd_addr[0] = 5;
        step("R3");
        idle();

        // R4: forwarding from the latched stage, later cycle wins
        ren_wen[0] = 1'b1; ren_waddr[0] = 6; ren_wpreg[0] = 41;
        step("R4");
        idle(); rd_en[0] = 1'b1; rd_addr[0] = 6;
        step("R4");
        idle(); ren_wen[0] = 1'b1; ren_waddr[0] = 7; ren_wpreg[0] = 50;
        step("R4");
        idle(); ren_wen[0] = 1'b1; ren_waddr[0] = 7; ren_wpreg[0] = 51;
        rd_en[1] = 1'b1; rd_addr[1] = 7;
        step("R4");
        idle(); rd_en[2] = 1'b1; rd_addr[2] = 7;
        step("R4");
        idle();

        // R5: highest port wins within a cycle
        ren_wen = '1; ren_waddr[0] = 8; ren_wpreg[0] = 60; ren_waddr[1] = 8; ren_wpreg[1] = 61;
        rd_en[0] = 1'b1; rd_addr[0] = 8;
        step("R5");
        idle(); rd_en[3] = 1'b1; rd_addr[3] = 8;
        step("R5");
        step("R5");
        idle();

        // R6: register 0 ignores updates
        ren_wen[1] = 1'b1; ren_waddr[1] = 0; ren_wpreg[1] = 99;
        cmt_wen[0] = 1'b1; cmt_waddr[0] = 0; cmt_wpreg[0] = 98;
        rd_en[0] = 1'b1; rd_addr[0] = 0;
        step("R6");
        idle(); rd_en[0] = 1'b1; rd_addr[0] = 0;
        step("R6");
        idle();

        // R9: commits stay out of the speculative map
        cmt_wen = '1; cmt_waddr[0] = 5; cmt_wpreg[0] = 70; cmt_waddr[1] = 5; cmt_wpreg[1] = 71;
        rd_en[0] = 1'b1; rd_addr[0] = 5;
        step("R9");
        idle(); rd_en[0] = 1'b1; rd_addr[0] = 5;
        step("R9");
        idle();

        // R7 / R8: redirect drops rename updates and restores committed state
        ren_wen[0] = 1'b1; ren_waddr[0] = 9; ren_wpreg[0] = 77;
        step("R7");
        idle(); redirect = 1'b1; rd_en = '1;
        ren_wen[0] = 1'b1; ren_waddr[0] = 11; ren_wpreg[0] = 80;
        cmt_wen[0] = 1'b1; cmt_waddr[0] = 10; cmt_wpreg[0] = 90;
        step("R8");
        idle(); rd_en = '1;
        rd_addr[0] = 5; rd_addr[1] = 9; rd_addr[2] = 10; rd_addr[3] = 11;
        step("R7");
        rd_addr[0] = 8; rd_addr[1] = 0; rd_addr[2] = 6; rd_addr[3] = 7;
        step("R7");
        idle();

        // R2: random interleaving of lookups, updates and redirects
        for (int n = 0; n < 4000; n++) begin
            bit narrow;
            narrow = ($urandom_range(0, 1) == 1);
            redirect = ($urandom_range(0, 19) == 0);
            for (int i = 0; i < NR; i++) begin
                rd_en[i] = ($urandom_range(0, 3) != 0);
                rd_addr[i] = narrow ? AW'($urandom_range(0, 7)) : AW'($urandom_range(0, NA - 1));
            end
            for (int w = 0; w < NW; w++) begin
                ren_wen[w] = ($urandom_range(0, 1) == 1);
                ren_waddr[w] = narrow ? AW'($urandom_range(0, 7)) : AW'($urandom_range(0, NA - 1));
                ren_wpreg[w] = PW'($urandom_range(0, (1 << PW) - 1));
            end
            for (int c = 0; c < NC; c++) begin
                cmt_wen[c] = ($urandom_range(0, 2) == 0);
                cmt_waddr[c] = narrow ? AW'($urandom_range(0, 7)) : AW'($urandom_range(0, NA - 1));
                cmt_wpreg[c] = PW'($urandom_range(0, (1 << PW) - 1));
            end
            step("R2");
        end
        idle();
        step("R2");
        step("R2");
        @(negedge clk);
        finished = 1;
        summary();
    end
endmodule